// File: doc/BRIEF.md
# Integer Divide Unit

This block divides a double-width dividend by a single-width divisor, either as unsigned numbers or as two's-complement numbers. The dividend, quotient and remainder use fixed implicit register roles, and the ports mirror those roles. Two inputs, `in_dx` (high half) and `in_ax` (low half), carry the dividend. Two registered outputs, `out_ax` and `out_dx`, hold the results. The outputs keep their values between operations, as an architectural register pair would. A size select chooses half-width (byte) or full-width (word) operation. The divisor enters on a separate port.

The operands enter on a valid/ready handshake. `in_ready` is high only while the unit is idle. An operation is accepted on a rising edge where both `in_valid` and `in_ready` are high. While an operation is in flight, `in_valid` is ignored and the upstream side must hold its request. The result side has no back-pressure. `out_valid` is a single-cycle pulse, and `out_err` qualifies it. The results stay on `out_ax`/`out_dx` until the next successful operation.

The quotient is built one bit per clock by a restoring shift-subtract loop on operand magnitudes. Signs are applied afterwards. A zero divisor, or a quotient that does not fit the destination, reports a divide error and leaves both result registers untouched.

Top module: `int_divider`

## Requirements
- R1: Byte mode (`in_word`=0) takes the 16-bit dividend from `in_ax` and the divisor from `in_src[7:0]`. On success, `out_ax[7:0]` holds the quotient, `out_ax[15:8]` holds the remainder, and `out_dx` is unchanged.
- R2: Word mode (`in_word`=1) takes the dividend `{in_dx,in_ax}` and the 16-bit divisor `in_src`. On success, `out_ax` holds the quotient and `out_dx` holds the remainder.
- R3: With `in_signed`=0 the operands are unsigned, and the results satisfy dividend = quotient*divisor + remainder with remainder < divisor.
- R4: With `in_signed`=1 the operands are two's complement, and a non-integral quotient is truncated toward zero.
- R5: In signed mode a nonzero remainder has the sign of the dividend.
- R6: A zero divisor (only the low 8 bits count in byte mode) raises `out_err`.
- R7: A quotient outside the destination range raises `out_err`. The unsigned range is 0..255 (byte) or 0..65535 (word). Example: signed 251 / -1 in byte mode.
- R8: In signed mode a quotient of exactly -128 (byte) or -32768 (word) raises `out_err`. The limits ±127 and ±32767 are accepted.
- R9: When `out_err` is reported, `out_ax` and `out_dx` keep their previous values.
- R10: `out_valid` is high for exactly one cycle per accepted operation. It rises 1 cycle after acceptance on an error found up front (zero divisor or too-large high half). Otherwise it rises 9 cycles after acceptance in byte mode and 17 in word mode, and the range check of R8 also reports at that time. `out_ax`/`out_dx` change only in that cycle.
- R11: `in_ready` is low from the cycle after acceptance until the result cycle. Requests presented during that time are neither accepted nor produce results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit idle, request will be accepted |
| in_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| in_word | input | 1 | 1 = word mode, 0 = byte mode |
| in_dx | input | 16 | Dividend high half (word mode) |
| in_ax | input | 16 | Dividend low half (word) or whole dividend (byte) |
| in_src | input | 16 | Divisor (low 8 bits in byte mode) |
| out_valid | output | 1 | One-cycle result pulse |
| out_err | output | 1 | Divide error, qualified by out_valid |
| out_ax | output | 16 | Quotient register (byte: remainder:quotient) |
| out_dx | output | 16 | Remainder register (word mode) |

## Verification
Each result is due a fixed number of cycles after its acceptance edge. An up-front error is due 1 cycle later. A completed byte divide is due 9 cycles later and a completed word divide 17 cycles later. When the driver hands an operation over, it records the acceptance cycle and the expected delay. The monitor runs on falling edges. It compares the cycle in which it sees `out_valid` against that record, and then compares `out_err`, `out_ax` and `out_dx` against values computed by integer arithmetic in the bench. Requests made while the unit is busy must produce no extra results, so any pulse that arrives with an empty queue counts as a failure.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, result signs and early overflow test.
module div_prep #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic         word_i,
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] ax_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] dmag_o,
  output logic         q_neg_o,
  output logic         r_neg_o,
  output logic         ovf_o
);
  localparam int BW = W / 2;

  logic [2*W-1:0] dvd_raw, dvd_mag;
  logic [W-1:0]   dsr_raw;
  logic           dvd_neg, dsr_neg;

  always_comb begin
    if (word_i)        dvd_raw = {dx_i, ax_i};
    else if (signed_i) dvd_raw = {{W{ax_i[W-1]}}, ax_i};
    else               dvd_raw = {{W{1'b0}}, ax_i};

    if (word_i)        dsr_raw = src_i;
    else if (signed_i) dsr_raw = {{BW{src_i[BW-1]}}, src_i[BW-1:0]};
    else               dsr_raw = {{BW{1'b0}}, src_i[BW-1:0]};

    dvd_neg = signed_i & dvd_raw[2*W-1];
    dsr_neg = signed_i & dsr_raw[W-1];
    dvd_mag = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
    dmag_o  = dsr_neg ? (~dsr_raw + 1'b1) : dsr_raw;

    if (word_i) begin
      hi_o = dvd_mag[2*W-1:W];
      lo_o = dvd_mag[W-1:0];
    end else begin
      hi_o = {{BW{1'b0}}, dvd_mag[W-1:BW]};
      lo_o = {dvd_mag[BW-1:0], {BW{1'b0}}};
    end

    // Quotient magnitude needs more than the destination width (or divisor is zero)
    ovf_o   = (hi_o >= dmag_o);
    q_neg_o = dvd_neg ^ dsr_neg;
    r_neg_o = dvd_neg;
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract iteration on magnitudes, one quotient bit per step.
module div_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dmag_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, quo_q, dsr_q;
  logic [W:0]   trial, diff;
  logic         fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dsr_q};
    fits  = (trial >= {1'b0, dsr_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load_i) begin
      rem_q <= hi_i;
      quo_q <= lo_i;
      dsr_q <= dmag_i;
    end else if (step_i) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/div_post.sv
// Sign restoration, signed range limit and placement into result registers.
module div_post #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic         word_i,
  input  logic         q_neg_i,
  input  logic         r_neg_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] prior_dx_i,
  output logic [W-1:0] res_ax_o,
  output logic [W-1:0] res_dx_o,
  output logic         range_err_o
);
  localparam int BW = W / 2;

  logic [W-1:0] qmag, limit, q_s, r_s;

  always_comb begin
    qmag  = word_i ? quo_i : {{BW{1'b0}}, quo_i[BW-1:0]};
    limit = word_i ? {1'b0, {(W-1){1'b1}}} : {{(BW+1){1'b0}}, {(BW-1){1'b1}}};
    range_err_o = signed_i & (qmag > limit);

    q_s = q_neg_i ? (~quo_i + 1'b1) : quo_i;
    r_s = r_neg_i ? (~rem_i + 1'b1) : rem_i;

    if (word_i) begin
      res_ax_o = q_s;
      res_dx_o = r_s;
    end else begin
      res_ax_o = {r_s[BW-1:0], q_s[BW-1:0]};
      res_dx_o = prior_dx_i;
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_signed,
  input  logic         in_word,
  input  logic [W-1:0] in_dx,
  input  logic [W-1:0] in_ax,
  input  logic [W-1:0] in_src,
  output logic         out_valid,
  output logic         out_err,
  output logic [W-1:0] out_ax,
  output logic [W-1:0] out_dx
);
  import div_pkg::*;

  localparam int BW = W / 2;
  localparam int CW = $clog2(W);

  div_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic         sgn_q, word_q, qneg_q, rneg_q, perr_q;
  logic         valid_q, err_q;
  logic [W-1:0] ax_q, dx_q;

  logic [W-1:0] p_hi, p_lo, p_dmag, c_quo, c_rem, r_ax, r_dx;
  logic         p_qneg, p_rneg, p_ovf, r_range;
  logic         accept, step;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign step     = (state_q == ST_RUN);

  div_prep #(.W(W)) u_prep (
    .signed_i (in_signed),
    .word_i   (in_word),
    .dx_i     (in_dx),
    .ax_i     (in_ax),
    .src_i    (in_src),
    .hi_o     (p_hi),
    .lo_o     (p_lo),
    .dmag_o   (p_dmag),
    .q_neg_o  (p_qneg),
    .r_neg_o  (p_rneg),
    .ovf_o    (p_ovf)
  );

  div_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (step),
    .hi_i   (p_hi),
    .lo_i   (p_lo),
    .dmag_i (p_dmag),
    .quo_o  (c_quo),
    .rem_o  (c_rem)
  );

  div_post #(.W(W)) u_post (
    .signed_i    (sgn_q),
    .word_i      (word_q),
    .q_neg_i     (qneg_q),
    .r_neg_i     (rneg_q),
    .quo_i       (c_quo),
    .rem_i       (c_rem),
    .prior_dx_i  (dx_q),
    .res_ax_o    (r_ax),
    .res_dx_o    (r_dx),
    .range_err_o (r_range)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      word_q  <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      perr_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      ax_q    <= '0;
      dx_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sgn_q  <= in_signed;
          word_q <= in_word;
          qneg_q <= p_qneg;
          rneg_q <= p_rneg;
          perr_q <= p_ovf;
          cnt_q  <= in_word ? CW'(W - 1) : CW'(BW - 1);
          state_q <= p_ovf ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FIN: begin
          valid_q <= 1'b1;
          err_q   <= perr_q | r_range;
          if (!(perr_q | r_range)) begin
            ax_q <= r_ax;
            dx_q <= r_dx;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_ax    = ax_q;
  assign out_dx    = dx_q;
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_signed,
  input logic         in_word,
  input logic [W-1:0] in_dx,
  input logic [W-1:0] in_ax,
  input logic [W-1:0] in_src,
  input logic         out_valid,
  input logic         out_err,
  input logic [W-1:0] out_ax,
  input logic [W-1:0] out_dx
);
  localparam int BW = W / 2;

  logic p_word, p_signed, p_dneg, p_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_word <= 1'b0; p_signed <= 1'b0; p_dneg <= 1'b0; p_zero <= 1'b0;
    end else if (in_valid && in_ready) begin
      p_word   <= in_word;
      p_signed <= in_signed;
      p_dneg   <= in_word ? in_dx[W-1] : in_ax[W-1];
      p_zero   <= in_word ? (in_src == '0) : (in_src[BW-1:0] == '0);
    end
  end

  // R10: result pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10: result registers move only with the pulse
  a_r10_quiet_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_ax) && $stable(out_dx)));

  // R11: unit goes busy after an accepted request
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: error leaves both result registers untouched
  a_r9_err_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> ($stable(out_ax) && $stable(out_dx)));

  // R1: byte mode never writes the high result register
  a_r1_byte_keeps_dx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !p_word) |-> $stable(out_dx));

  // R6: zero divisor always reports an error
  a_r6_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_zero) |-> out_err);

  // R5: signed nonzero remainder follows dividend sign
  a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && p_signed &&
     (p_word ? (out_dx != '0) : (out_ax[W-1:BW] != '0)))
    |-> ((p_word ? out_dx[W-1] : out_ax[W-1]) == p_dneg));
endmodule

bind int_divider int_divider_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_signed (in_signed),
  .in_word   (in_word),
  .in_dx     (in_dx),
  .in_ax     (in_ax),
  .in_src    (in_src),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_ax    (out_ax),
  .out_dx    (out_dx)
);

// File: tb/int_divider_tb_top.sv
`timescale 1ns/1ps
module int_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_signed = 1'b0, in_word = 1'b0;
  logic [15:0] in_dx = '0, in_ax = '0, in_src = '0;
  logic        in_ready, out_valid, out_err;
  logic [15:0] out_ax, out_dx;

  always #5 clk = ~clk;

  int_divider #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_word(in_word), .in_dx(in_dx), .in_ax(in_ax),
    .in_src(in_src), .out_valid(out_valid), .out_err(out_err),
    .out_ax(out_ax), .out_dx(out_dx)
  );

  typedef struct {
    logic        err;
    logic [15:0] ax;
    logic [15:0] dx;
    longint      acc;
    int          lat;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     errors = 0, checks = 0;
  longint cyc = 0;
  logic [15:0] m_ax = '0, m_dx = '0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: compute expectation, push, then hand operation to the unit
  task automatic do_div(input bit sgn, input bit wrd, input logic [15:0] dx,
                        input logic [15:0] ax, input logic [15:0] src, input string tag);
    exp_t   e;
    longint nd, dv, q, r, hi, lo;
    bit     early;
    if (wrd) begin
      nd = sgn ? longint'($signed({dx, ax})) : longint'({dx, ax});
      dv = sgn ? longint'($signed(src)) : longint'(src);
    end else begin
      nd = sgn ? longint'($signed(ax)) : longint'(ax);
      dv = sgn ? longint'($signed(src[7:0])) : longint'(src[7:0]);
    end
    hi = sgn ? (wrd ? 32767 : 127) : (wrd ? 65535 : 255);
    lo = sgn ? -hi : 0;
    e.tag = tag;
    if (dv == 0) begin
      e.err = 1; early = 1;
    end else begin
      q = nd / dv; r = nd % dv;
      // magnitude quotient at least 2^N is found up front
      early = ((q < 0 ? -q : q) >= (wrd ? 65536 : 256));
      e.err = (q > hi) || (q < lo);
      if (!e.err) begin
        if (wrd) begin m_ax = q[15:0]; m_dx = r[15:0]; end
        else     m_ax = {r[7:0], q[7:0]};
      end
    end
    e.ax  = m_ax; e.dx = m_dx;
    e.lat = early ? 1 : (wrd ? 17 : 9);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_signed = sgn; in_word = wrd; in_dx = dx; in_ax = ax; in_src = src;
    in_valid = 1'b1;
    e.acc = cyc + 1;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: pop and compare when a result pulse is seen
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R11 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk((cyc - e.acc) == e.lat, {e.tag, " R10 latency"}, cyc - e.acc, e.lat);
        chk(out_err == e.err, {e.tag, " err"}, out_err, e.err);
        chk(out_ax == e.ax, {e.tag, " ax"}, out_ax, e.ax);
        chk(out_dx == e.dx, {e.tag, " dx"}, out_dx, e.dx);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog: actual cycle %0d expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 reset ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
    chk(out_ax == 16'h0 && out_dx == 16'h0, "R9 reset regs", {out_dx, out_ax}, 0);
    rst_n = 1'b1;

    do_div(0, 0, 16'hAAAA, 16'd100, 16'h0007, "R1 R3 byte unsigned");
    do_div(0, 1, 16'h0001, 16'h0000, 16'h0003, "R2 R3 word unsigned");
    do_div(1, 0, 16'h0000, 16'hFFF9, 16'h0002, "R4 R5 byte -7/2");
    do_div(1, 0, 16'h0000, 16'h0007, 16'h00FE, "R4 R5 byte 7/-2");
    do_div(1, 1, 16'hFFFE, 16'h7960, 16'h0007, "R4 R5 word -100000/7");
    do_div(1, 1, 16'h0000, 16'h0064, 16'hFFF9, "R4 R5 word 100/-7");
    do_div(0, 1, 16'h1234, 16'h5678, 16'h0000, "R6 R9 word zero divisor");
    do_div(1, 0, 16'h0000, 16'h0040, 16'h1200, "R6 R9 byte zero low divisor");
    do_div(0, 0, 16'h0000, 16'h0300, 16'h0003, "R7 R9 byte unsigned 256");
    do_div(0, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R7 R9 word unsigned big");
    do_div(1, 0, 16'h0000, 16'h00FB, 16'h00FF, "R7 R9 byte 251/-1");
    do_div(0, 0, 16'h0000, 16'h0100, 16'h0002, "R3 byte unsigned 128");
    do_div(1, 0, 16'h0000, 16'hFF00, 16'h0002, "R8 byte -128");
    do_div(1, 1, 16'hFFFF, 16'h0000, 16'h0002, "R8 word -32768");
    do_div(1, 0, 16'h0000, 16'h00FE, 16'h0002, "R8 byte +127");
    do_div(1, 0, 16'h0000, 16'hFF02, 16'h0002, "R8 byte -127");
    do_div(1, 1, 16'hFFFF, 16'h0002, 16'h0002, "R8 word -32767");

    // R11: requests while busy are ignored
    do_div(0, 1, 16'h0000, 16'h4000, 16'h0010, "R11 busy target");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R11 busy ready", in_ready, 0);
      in_word = 1'b0; in_ax = 16'h0055; in_src = 16'h0000; in_valid = 1'b1;
    end
    @(negedge clk) in_valid = 1'b0;

    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, d, s;
      a = 16'($urandom); d = 16'($urandom); s = 16'($urandom);
      if (i % 3 == 0) d = {16{a[15]}};
      do_div(i[0], i[1], d, a, s, "R3 R4 R5 R7 mixed");
    end

    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R10 all results seen", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule